// File: doc/BRIEF.md
# Slow-Clock Reset Controller with Key-Chord Reset

This block produces the internal reset of a small low-power chip that runs from a 32.768 kHz clock. Two sources can start a reset. One is an active-low reset pin. The other is a chord of key inputs that are all held low at the same time. A set/reset latch holds the reset. Either source sets it. It is cleared only while the 2 Hz tap of a free-running divider is high. Because of this, reset always ends in step with the slow time base, up to half a 2 Hz period after the last source goes away.

The key chord passes through a noise filter. The condition must hold for a programmable number of consecutive clock cycles, and any break starts the count again. An optional hold stage can follow the filter. With it enabled, the chord must still be held across two rising edges of the 1 Hz tap, which is 1 to 2 seconds at the real clock rate. Parameters choose the chord, the filter length, the hold stage and the divider width. A synchronous power-on clear (`por`) is the only thing that clears the divider and the other registers. The divider keeps counting while reset is active.

Top module: `rc_reset_ctl`

## Requirements
- R1: While `por` is high, `sys_rst` is high. The divider restarts from zero, so after the n-th clock edge following `por` release the divider holds n modulo 2^DIV_W. After release, `sys_rst` stays high until the first release edge allowed by R4.
- R2: The pin is sampled by two flops. When `rst_pin_n` is low at a single rising edge a, `sys_rst` is high after edge a+2.
- R3: As long as the synchronized pin is low, `sys_rst` stays high, whatever the divider taps do.
- R4: `sys_rst` clears only at an edge e where divider bit DIV_W-2 (the 2 Hz tap) was 1 before that edge, and where no source is active. For the pin, that is the first such edge at or after a+2, where a is the first edge at which the pin is seen high.
- R5: KEY_SEL picks the chord: KEYS_NONE (no key reset), KEYS_ALL4 (keys 0-3), KEYS_LOW3 (keys 0-2) or KEYS_LOW2 (keys 0-1). Bit i of `keys_n` is key i. The chord is active only when every selected key is low. Keys that are not selected are ignored.
- R6: The keys are synchronized by two flops. An active chord that is first seen at edge a and held for exactly NR_CYCLES edges, with TA_EN=0, sets `sys_rst` after edge a+NR_CYCLES+2. A chord held for NR_CYCLES-1 edges has no effect.
- R7: A key reset holds `sys_rst` high while the chord is held. Release then follows R4, at or after edge a+L+3 for a chord held L edges (a+L+4 with TA_EN=1).
- R8: With TA_EN=1, let e1 be the first rising edge of the 1 Hz tap (divider bit DIV_W-1) that comes after the filter is satisfied. Let e2 be the next rising edge of that tap. `sys_rst` goes high after edge e2+1, provided the filter stays satisfied the whole time.
- R9: With TA_EN=1, a chord whose filtered span covers fewer than two 1 Hz rising edges never causes a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock (32.768 kHz in the target) |
| por | input | 1 | Synchronous active-high power-on clear |
| rst_pin_n | input | 1 | Asynchronous active-low reset pin |
| keys_n | input | 4 | Asynchronous key inputs, low means pressed |
| sys_rst | output | 1 | Internal reset, active high |

## Verification
The key path gets chords of several lengths. One is one cycle short of the filter length, which must be ignored. One is exactly the filter length, which must reset. One is held long, which shows that reset persists and that release waits for the 2 Hz tap. Partial chords run against three configurations (all four keys, two keys with the hold stage, and no chord) to show that only the selected keys count. One-cycle and long pin pulses separate "captured" from "held", and the computed release edges show that the divider keeps running through reset. A long two-key hold locates the exact 1 Hz edge pair that qualifies the reset. Shorter holds confirm that one edge is not enough.

// File: rtl/rc_pkg.sv
package rc_pkg;

    typedef enum logic [1:0] {
        KEYS_NONE = 2'd0,
        KEYS_ALL4 = 2'd1,
        KEYS_LOW3 = 2'd2,
        KEYS_LOW2 = 2'd3
    } key_sel_e;

    // Selected keys as a bit mask; bit i stands for key i.
    function automatic logic [3:0] key_mask(key_sel_e sel);
        case (sel)
            KEYS_ALL4: return 4'b1111;
            KEYS_LOW3: return 4'b0111;
            KEYS_LOW2: return 4'b0011;
            default:   return 4'b0000;
        endcase
    endfunction

    typedef struct packed {
        logic tap_2hz;
        logic tap_1hz;
        logic rise_1hz;
    } taps_t;

endpackage

// File: rtl/rc_divider.sv
module rc_divider #(
    parameter int DIV_W = 15
) (
    input  logic          clk,
    input  logic          por,
    output rc_pkg::taps_t taps
);
    logic [DIV_W-1:0] cnt;
    logic             slow_q;

    always_ff @(posedge clk) begin
        if (por) begin
            cnt    <= '0;
            slow_q <= 1'b0;
        end else begin
            cnt    <= cnt + 1'b1;
            slow_q <= cnt[DIV_W-1];
        end
    end

    always_comb begin
        taps.tap_2hz  = cnt[DIV_W-2];
        taps.tap_1hz  = cnt[DIV_W-1];
        taps.rise_1hz = cnt[DIV_W-1] & ~slow_q;
    end
endmodule

// File: rtl/rc_sync.sv
module rc_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         por,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (por) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/rc_key_qual.sv
module rc_key_qual #(
    parameter int               NR_CYCLES = 49,
    parameter bit               TA_EN     = 1'b0,
    parameter rc_pkg::key_sel_e KEY_SEL   = rc_pkg::KEYS_ALL4
) (
    input  logic       clk,
    input  logic       por,
    input  logic [3:0] keys_s,
    input  logic       rise_1hz,
    output logic       key_hit
);
    localparam int          NR_W = $clog2(NR_CYCLES + 1);
    localparam logic [3:0]  MASK = rc_pkg::key_mask(KEY_SEL);
    localparam logic [NR_W-1:0] NR_MAX = NR_W'(NR_CYCLES);

    logic            chord;
    logic [NR_W-1:0] run_cnt;
    logic            filt_ok;

    assign chord   = (MASK != 4'b0000) && ((keys_s & MASK) == 4'b0000);
    assign filt_ok = (run_cnt == NR_MAX);

    // Noise filter: consecutive cycles, restart on any break.
    always_ff @(posedge clk) begin
        if (por || !chord)
            run_cnt <= '0;
        else if (!filt_ok)
            run_cnt <= run_cnt + 1'b1;
    end

    generate
        if (TA_EN) begin : g_hold
            logic armed;
            logic hit_q;
            always_ff @(posedge clk) begin
                if (por || !filt_ok) begin
                    armed <= 1'b0;
                    hit_q <= 1'b0;
                end else if (rise_1hz) begin
                    if (armed)
                        hit_q <= 1'b1;
                    armed <= 1'b1;
                end
            end
            assign key_hit = hit_q;
        end else begin : g_direct
            assign key_hit = filt_ok;
        end
    endgenerate
endmodule

// File: rtl/rc_rst_latch.sv
module rc_rst_latch (
    input  logic clk,
    input  logic por,
    input  logic set_req,
    input  logic tap_2hz,
    output logic rst_q
);
    always_ff @(posedge clk) begin
        if (por || set_req)
            rst_q <= 1'b1;
        else if (tap_2hz)
            rst_q <= 1'b0;
    end
endmodule

// File: rtl/rc_reset_ctl.sv
module rc_reset_ctl #(
    parameter int               DIV_W     = 15,
    parameter int               NR_CYCLES = 49,
    parameter bit               TA_EN     = 1'b0,
    parameter rc_pkg::key_sel_e KEY_SEL   = rc_pkg::KEYS_ALL4
) (
    input  logic       clk,
    input  logic       por,
    input  logic       rst_pin_n,
    input  logic [3:0] keys_n,
    output logic       sys_rst
);
    rc_pkg::taps_t taps;
    logic          tap_2hz;
    logic          rise_1hz;
    logic          pin_sync;
    logic [3:0]    keys_s;
    logic          key_hit;

    rc_divider #(.DIV_W(DIV_W)) u_div (
        .clk (clk),
        .por (por),
        .taps(taps)
    );
    assign tap_2hz  = taps.tap_2hz;
    assign rise_1hz = taps.rise_1hz;

    rc_sync #(.W(1), .RST_VAL(1'b0)) u_pin_sync (
        .clk(clk),
        .por(por),
        .d  (rst_pin_n),
        .q  (pin_sync)
    );

    rc_sync #(.W(4), .RST_VAL(4'hF)) u_key_sync (
        .clk(clk),
        .por(por),
        .d  (keys_n),
        .q  (keys_s)
    );

    rc_key_qual #(
        .NR_CYCLES(NR_CYCLES),
        .TA_EN    (TA_EN),
        .KEY_SEL  (KEY_SEL)
    ) u_keys (
        .clk     (clk),
        .por     (por),
        .keys_s  (keys_s),
        .rise_1hz(rise_1hz),
        .key_hit (key_hit)
    );

    rc_rst_latch u_latch (
        .clk    (clk),
        .por    (por),
        .set_req(~pin_sync | key_hit),
        .tap_2hz(tap_2hz),
        .rst_q  (sys_rst)
    );
endmodule

// File: rtl/rc_reset_ctl_chk.sv
module rc_reset_ctl_chk #(
    parameter bit               TA_EN   = 1'b0,
    parameter rc_pkg::key_sel_e KEY_SEL = rc_pkg::KEYS_ALL4
) (
    input logic clk,
    input logic por,
    input logic rst_pin_n,
    input logic pin_sync,
    input logic tap_2hz,
    input logic rise_1hz,
    input logic key_hit,
    input logic sys_rst
);
    p_pin_sets_r2: assert property (@(posedge clk) disable iff (por)
        !$past(rst_pin_n, 3) |-> sys_rst);

    p_pin_holds_r3: assert property (@(posedge clk) disable iff (por)
        !pin_sync |=> sys_rst);

    p_release_tap_r4: assert property (@(posedge clk) disable iff (por)
        $fell(sys_rst) |-> ($past(tap_2hz) && $past(pin_sync) && !$past(key_hit)));

    p_key_none_r5: assert property (@(posedge clk) disable iff (por)
        key_hit |-> (KEY_SEL != rc_pkg::KEYS_NONE));

    p_key_holds_r7: assert property (@(posedge clk) disable iff (por)
        key_hit |=> sys_rst);

    p_hold_edge_r8: assert property (@(posedge clk) disable iff (por)
        $rose(key_hit) |-> (!TA_EN || $past(rise_1hz)));
endmodule

bind rc_reset_ctl rc_reset_ctl_chk #(.TA_EN(TA_EN), .KEY_SEL(KEY_SEL)) u_chk (
    .clk      (clk),
    .por      (por),
    .rst_pin_n(rst_pin_n),
    .pin_sync (pin_sync),
    .tap_2hz  (tap_2hz),
    .rise_1hz (rise_1hz),
    .key_hit  (key_hit),
    .sys_rst  (sys_rst)
);

// File: tb/tb_rc_reset_ctl.sv
module tb_rc_reset_ctl;
    localparam int W  = 6;
    localparam int NR = 5;
    localparam int WATCHDOG = 20000;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       rst_pin_n = 1'b1;
    logic [3:0] keys_n = 4'hF;
    logic       rst_a, rst_ta, rst_none;
    int         cyc = 0;
    int         n_chk = 0;
    int         n_bad = 0;
    int         wd = 0;

    always #5 clk = ~clk;

    rc_reset_ctl #(.DIV_W(W), .NR_CYCLES(NR), .TA_EN(1'b0), .KEY_SEL(rc_pkg::KEYS_ALL4)) dut (
        .clk(clk), .por(por), .rst_pin_n(rst_pin_n), .keys_n(keys_n), .sys_rst(rst_a));
    rc_reset_ctl #(.DIV_W(W), .NR_CYCLES(NR), .TA_EN(1'b1), .KEY_SEL(rc_pkg::KEYS_LOW2)) dut_ta (
        .clk(clk), .por(por), .rst_pin_n(rst_pin_n), .keys_n(keys_n), .sys_rst(rst_ta));
    rc_reset_ctl #(.DIV_W(W), .NR_CYCLES(NR), .TA_EN(1'b0), .KEY_SEL(rc_pkg::KEYS_NONE)) dut_none (
        .clk(clk), .por(por), .rst_pin_n(rst_pin_n), .keys_n(keys_n), .sys_rst(rst_none));

    typedef struct {
        int    edge_n;
        int    unit;
        logic  val;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    always @(posedge clk) if (!por) cyc <= cyc + 1;

    function automatic logic unit_val(int u);
        case (u)
            0: return rst_a;
            1: return rst_ta;
            default: return rst_none;
        endcase
    endfunction

    function automatic int relfrom(int s);
        for (int e = s; e < s + (1 << W) + 2; e++)
            if ((((e - 1) >> (W - 2)) & 1) == 1) return e;
        return s;
    endfunction

    function automatic int rise_from(int s);
        for (int e = s; e < s + (1 << W) + 2; e++)
            if (((e - 1) % (1 << W)) == (1 << (W - 1))) return e;
        return s;
    endfunction

    task automatic push(int e, int u, logic v, string tag);
        exp_t it;
        it.edge_n = e; it.unit = u; it.val = v; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic push_all(int e, logic v, string tag);
        for (int u = 0; u < 3; u++) push(e, u, v, tag);
    endtask

    // Monitor: compares results after each edge, away from the active edge.
    always @(negedge clk) begin
        for (int i = exp_q.size() - 1; i >= 0; i--) begin
            if (exp_q[i].edge_n <= cyc) begin
                n_chk++;
                if (exp_q[i].edge_n != cyc || unit_val(exp_q[i].unit) !== exp_q[i].val) begin
                    n_bad++;
                    $display("FAIL %s unit%0d edge %0d (now %0d): actual %0b expected %0b",
                             exp_q[i].tag, exp_q[i].unit, exp_q[i].edge_n, cyc,
                             unit_val(exp_q[i].unit), exp_q[i].val);
                end
                exp_q.delete(i);
            end
        end
    end

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Drive a key pattern seen first at edge a (returned), held for L edges.
    task automatic hold_keys(logic [3:0] pat, int L, output int a);
        a = cyc + 1;
        keys_n = pat;
        repeat (L) @(negedge clk);
        keys_n = 4'hF;
    endtask

    initial begin
        int a, r, e1, e2;
        // R1: reset state during power-on clear
        repeat (4) @(negedge clk);
        n_chk++;
        if ({rst_a, rst_ta, rst_none} !== 3'b111) begin
            n_bad++;
            $display("FAIL R1 during por: actual %b expected 111", {rst_a, rst_ta, rst_none});
        end
        por = 1'b0;
        r = relfrom(3);
        push_all(r - 1, 1'b1, "R1");
        push_all(r, 1'b0, "R4");
        drain();

        // R2: single-cycle pin pulse is captured; R4 release on tap
        a = cyc + 1;
        rst_pin_n = 1'b0;
        @(negedge clk);
        rst_pin_n = 1'b1;
        push_all(a + 1, 1'b0, "R2");
        push_all(a + 2, 1'b1, "R2");
        r = relfrom(a + 3);
        push_all(r - 1, 1'b1, "R4");
        push_all(r, 1'b0, "R4");
        drain();

        // R3: long pin low spans several tap-high phases
        a = cyc + 1;
        rst_pin_n = 1'b0;
        push(a + 40, 0, 1'b1, "R3");
        push(a + 79, 1, 1'b1, "R3");
        repeat (80) @(negedge clk);
        rst_pin_n = 1'b1;
        r = relfrom(a + 82);
        push_all(r - 1, 1'b1, "R4");
        push_all(r, 1'b0, "R4");
        drain();

        // R6: chord one cycle short of the filter is ignored
        hold_keys(4'b0000, NR - 1, a);
        push(a + NR + 2, 0, 1'b0, "R6");
        push(a + NR + 8, 0, 1'b0, "R6");
        push(a + NR + 8, 1, 1'b0, "R6");
        drain();

        // R5: partial chord (keys 0-2 low, key 3 high)
        hold_keys(4'b1000, NR + 10, a);
        push(a + NR + 12, 0, 1'b0, "R5");
        push(a + NR + 12, 2, 1'b0, "R5");
        push(a + NR + 12, 1, 1'b0, "R9");
        drain();

        // R6: chord of exactly the filter length resets
        hold_keys(4'b0000, NR, a);
        push(a + NR + 1, 0, 1'b0, "R6");
        push(a + NR + 2, 0, 1'b1, "R6");
        push(a + NR + 2, 2, 1'b0, "R5");
        push(a + NR + 2, 1, 1'b0, "R9");
        r = relfrom(a + NR + 3);
        push(r - 1, 0, 1'b1, "R7");
        push(r, 0, 1'b0, "R4");
        drain();

        // R7: long chord keeps reset; R9 hold stage sees under two 1 Hz edges
        hold_keys(4'b0000, NR + 30, a);
        push(a + NR + 30, 0, 1'b1, "R7");
        push(a + NR + 32, 1, 1'b0, "R9");
        push(a + NR + 32, 2, 1'b0, "R5");
        r = relfrom(a + NR + 33);
        push(r - 1, 0, 1'b1, "R7");
        push(r, 0, 1'b0, "R7");
        drain();

        // R8: two-key chord held long enough for two 1 Hz rising edges
        a = cyc + 1;
        e1 = rise_from(a + NR + 2);
        e2 = e1 + (1 << W);
        push(e2, 1, 1'b0, "R8");
        push(e2 + 1, 1, 1'b1, "R8");
        push(a + 199, 1, 1'b1, "R7");
        push(a + 199, 0, 1'b0, "R5");
        r = relfrom(a + 204);
        push(r - 1, 1, 1'b1, "R7");
        push(r, 1, 1'b0, "R7");
        keys_n = 4'b1100;
        repeat (200) @(negedge clk);
        keys_n = 4'hF;
        drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule